// File: doc/BRIEF.md
# Shared-Pin General-Purpose I/O Port

This block is an eight-pin general-purpose I/O port whose pins can be taken over by an SPI, two timer channels and a UART. Each pin has a bit in a data latch and a bit in a direction register. Software reaches both registers through a simple register bus. The block decides, for every pin, whether the port or a peripheral owns it. It then drives the pad output value and the output enable, and it returns read data that reflects the pad level for pins that are not driving.

The peripherals connect through enable, mode and output-value inputs. The port does not model the peripherals. It only resolves ownership and direction. The slave-select pin is the special case. Whether the port owns it depends on three things together: the SPI enable, master mode and mode-fault detection. While the SPI owns a pin, the direction register has no say over that pin.

Pin order, from bit 7 down to bit 0: SPI clock, MOSI, MISO, slave select, timer channel 1, timer channel 0, UART receive, UART transmit.

Top module: `gpio_share_port`

## Requirements
- R1: While `rst` is high at a clock edge, the direction register becomes 0x00. With no peripheral enabled, every `pad_oe` bit is then 0, and a read at `bus_addr`=1 returns 0x00.
- R2: A bus write (`bus_sel`=1, `bus_wr`=1, `bus_addr`=0, `rst`=0) loads `bus_wdata` into the data latch at the clock edge. A pin in port mode drives its latch bit on `pad_out`.
- R3: A bus write at `bus_addr`=1 loads the direction register, and a read at `bus_addr`=1 returns it. For a pin in port mode, `pad_oe` equals its direction bit, where 1 means output.
- R4: When `bus_sel`=1 and `bus_addr`=0, `bus_rdata` bit i is `pad_out[i]` if `pad_oe[i]` is 1, and `pad_in[i]` otherwise. When `bus_sel`=0, `bus_rdata` is 0x00.
- R5: While `spi_en`=1, pins 7 (clock) and 6 (MOSI) carry `spi_sck_o` and `spi_mosi_o`. Their `pad_oe` equals `spi_master`.
- R6: While `spi_en`=1, pin 5 (MISO) carries `spi_miso_o`. Its `pad_oe` equals the inverse of `spi_master`.
- R7: Pin 4 (slave select) is in port mode when `spi_en`=0, or when `spi_master`=1 and `spi_modf_en`=0. In every other case it is an input with `pad_oe`=0, whatever its direction bit says.
- R8: Reset leaves the data latch contents unchanged.
- R9: While `tmr1_en` (or `tmr0_en`) is 1, pin 3 (or pin 2) drives `tmr1_o` (or `tmr0_o`). Its `pad_oe` equals `tmr1_oe` (or `tmr0_oe`).
- R10: While `uart_rx_en`=1, pin 1 is an input. While `uart_tx_en`=1, pin 0 has `pad_oe`=1 and carries `uart_tx_o`.
- R11: A bus write with `bus_sel`=0 changes neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 1 | 0 = data latch, 1 = direction |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| spi_en | input | 1 | SPI enabled |
| spi_master | input | 1 | SPI in master mode |
| spi_modf_en | input | 1 | SPI mode-fault detection enabled |
| spi_sck_o | input | 1 | SPI clock value to drive |
| spi_mosi_o | input | 1 | MOSI value to drive |
| spi_miso_o | input | 1 | MISO value to drive |
| tmr1_en | input | 1 | Timer channel 1 owns pin 3 |
| tmr1_oe | input | 1 | Timer channel 1 drives |
| tmr1_o | input | 1 | Timer channel 1 value |
| tmr0_en | input | 1 | Timer channel 0 owns pin 2 |
| tmr0_oe | input | 1 | Timer channel 0 drives |
| tmr0_o | input | 1 | Timer channel 0 value |
| uart_rx_en | input | 1 | UART receiver owns pin 1 |
| uart_tx_en | input | 1 | UART transmitter owns pin 0 |
| uart_tx_o | input | 1 | UART transmit value |
| pad_in | input | 8 | Sampled pad levels |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables |

## Verification
The ownership logic is tried with four SPI mode combinations: disabled, master without fault detection, master with fault detection, and slave. This shows which terms of the slave-select rule are really in use, and it shows that MISO's direction is the opposite of the clock's. Each mode runs once with the direction register all ones and once with it all zeros, so a direction bit that leaks into a peripheral-owned pin shows up. Timer and UART takeovers run against the opposite direction setting. A long stretch of random pin levels, modes and bus traffic then checks the read-back path. There a pad level that differs from the driven value tells the driven-value path apart from the sampled-level path.

// File: rtl/gpio_share_pkg.sv
package gpio_share_pkg;

    localparam int NPIN     = 8;
    localparam int NSPI     = 4;
    localparam int NTMR     = 2;
    localparam int NUART    = 2;

    localparam int PIN_SCK  = 7;
    localparam int PIN_MOSI = 6;
    localparam int PIN_MISO = 5;
    localparam int PIN_SS   = 4;
    localparam int PIN_TC0  = 2;
    localparam int PIN_RX   = 1;
    localparam int PIN_TX   = 0;

    typedef enum logic {
        REG_DATA = 1'b0,
        REG_DIR  = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic owned;
        logic oe;
        logic val;
    } pin_req_t;

    typedef struct packed {
        logic en;
        logic master;
        logic modf_en;
        logic sck;
        logic mosi;
        logic miso;
    } spi_side_t;

    typedef struct packed {
        logic en;
        logic oe;
        logic val;
    } tmr_side_t;

    typedef struct packed {
        logic rx_en;
        logic tx_en;
        logic tx;
    } uart_side_t;

    function automatic logic ss_released(spi_side_t s);
        return !s.en || (s.master && !s.modf_en);
    endfunction

    function automatic pin_req_t mk_req(logic owned, logic oe, logic val);
        pin_req_t r;
        r.owned = owned;
        r.oe    = owned & oe;
        r.val   = owned & val;
        return r;
    endfunction

endpackage

// File: rtl/gpio_share_regs.sv
module gpio_share_regs
    import gpio_share_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            data_we,
    input  logic            dir_we,
    input  logic [NPIN-1:0] wdata,
    output logic [NPIN-1:0] data_q,
    output logic [NPIN-1:0] dir_q
);
    // The data latch has no reset on purpose.
    always_ff @(posedge clk) begin
        if (data_we && !rst) data_q <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst)         dir_q <= '0;
        else if (dir_we) dir_q <= wdata;
    end
endmodule

// File: rtl/gpio_share_owner.sv
module gpio_share_owner
    import gpio_share_pkg::*;
(
    input  spi_side_t              spi,
    input  tmr_side_t [NTMR-1:0]   tmr,
    input  uart_side_t             uart,
    output pin_req_t  [NPIN-1:0]   req
);
    pin_req_t [NSPI-1:0]  spi_req;
    pin_req_t [NTMR-1:0]  tmr_req;
    pin_req_t [NUART-1:0] uart_req;

    // SPI group, index 3..0 = clock, MOSI, MISO, slave select
    always_comb begin
        spi_req[3] = mk_req(spi.en, spi.master,  spi.sck);
        spi_req[2] = mk_req(spi.en, spi.master,  spi.mosi);
        spi_req[1] = mk_req(spi.en, !spi.master, spi.miso);
        spi_req[0] = mk_req(!ss_released(spi), 1'b0, 1'b0);
    end

    for (genvar k = 0; k < NTMR; k++) begin : g_tmr
        assign tmr_req[k] = mk_req(tmr[k].en, tmr[k].oe, tmr[k].val);
    end

    always_comb begin
        uart_req[1] = mk_req(uart.rx_en, 1'b0, 1'b0);
        uart_req[0] = mk_req(uart.tx_en, 1'b1, uart.tx);
    end

    assign req = {spi_req, tmr_req, uart_req};
endmodule

// File: rtl/gpio_share_mux.sv
module gpio_share_mux
    import gpio_share_pkg::*;
(
    input  pin_req_t [NPIN-1:0] req,
    input  logic     [NPIN-1:0] data_q,
    input  logic     [NPIN-1:0] dir_q,
    input  logic     [NPIN-1:0] pad_in,
    output logic     [NPIN-1:0] pad_out,
    output logic     [NPIN-1:0] pad_oe,
    output logic     [NPIN-1:0] rd_pins
);
    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        assign pad_oe[i]  = req[i].owned ? req[i].oe  : dir_q[i];
        assign pad_out[i] = req[i].owned ? req[i].val : data_q[i];
        assign rd_pins[i] = pad_oe[i] ? pad_out[i] : pad_in[i];
    end
endmodule

// File: rtl/gpio_share_port.sv
module gpio_share_port
    import gpio_share_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            bus_sel,
    input  logic            bus_wr,
    input  logic            bus_addr,
    input  logic [NPIN-1:0] bus_wdata,
    output logic [NPIN-1:0] bus_rdata,
    input  logic            spi_en,
    input  logic            spi_master,
    input  logic            spi_modf_en,
    input  logic            spi_sck_o,
    input  logic            spi_mosi_o,
    input  logic            spi_miso_o,
    input  logic            tmr1_en,
    input  logic            tmr1_oe,
    input  logic            tmr1_o,
    input  logic            tmr0_en,
    input  logic            tmr0_oe,
    input  logic            tmr0_o,
    input  logic            uart_rx_en,
    input  logic            uart_tx_en,
    input  logic            uart_tx_o,
    input  logic [NPIN-1:0] pad_in,
    output logic [NPIN-1:0] pad_out,
    output logic [NPIN-1:0] pad_oe
);
    reg_sel_e             sel;
    logic                 wr_hit;
    logic [NPIN-1:0]      data_q;
    logic [NPIN-1:0]      dir_q;
    logic [NPIN-1:0]      rd_pins;
    spi_side_t            spi;
    tmr_side_t [NTMR-1:0] tmr;
    uart_side_t           uart;
    pin_req_t  [NPIN-1:0] req;

    assign sel    = reg_sel_e'(bus_addr);
    assign wr_hit = bus_sel && bus_wr;

    assign spi  = '{en: spi_en, master: spi_master, modf_en: spi_modf_en,
                    sck: spi_sck_o, mosi: spi_mosi_o, miso: spi_miso_o};
    assign tmr[1] = '{en: tmr1_en, oe: tmr1_oe, val: tmr1_o};
    assign tmr[0] = '{en: tmr0_en, oe: tmr0_oe, val: tmr0_o};
    assign uart = '{rx_en: uart_rx_en, tx_en: uart_tx_en, tx: uart_tx_o};

    gpio_share_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .data_we(wr_hit && sel == REG_DATA),
        .dir_we (wr_hit && sel == REG_DIR),
        .wdata  (bus_wdata),
        .data_q (data_q),
        .dir_q  (dir_q)
    );

    gpio_share_owner u_owner (
        .spi (spi),
        .tmr (tmr),
        .uart(uart),
        .req (req)
    );

    gpio_share_mux u_mux (
        .req    (req),
        .data_q (data_q),
        .dir_q  (dir_q),
        .pad_in (pad_in),
        .pad_out(pad_out),
        .pad_oe (pad_oe),
        .rd_pins(rd_pins)
    );

    always_comb begin
        if (!bus_sel)             bus_rdata = '0;
        else if (sel == REG_DIR)  bus_rdata = dir_q;
        else                      bus_rdata = rd_pins;
    end
endmodule

// File: rtl/gpio_share_chk.sv
module gpio_share_chk
    import gpio_share_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            bus_sel,
    input logic            bus_wr,
    input logic            bus_addr,
    input logic [NPIN-1:0] bus_wdata,
    input logic            spi_en,
    input logic            spi_master,
    input logic            spi_modf_en,
    input logic            spi_sck_o,
    input logic            spi_miso_o,
    input logic            tmr1_en,
    input logic            tmr1_oe,
    input logic            uart_rx_en,
    input logic            uart_tx_en,
    input logic            uart_tx_o,
    input logic [NPIN-1:0] pad_out,
    input logic [NPIN-1:0] pad_oe,
    input logic [NPIN-1:0] data_q,
    input logic [NPIN-1:0] dir_q
);
    a_r1_dir_cleared: assert property (@(posedge clk)
        rst |=> dir_q == '0);

    a_r2_latch_load: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_wr && !bus_addr) |=> data_q == $past(bus_wdata));

    a_r3_tc1_dir: assert property (@(posedge clk) disable iff (rst)
        !tmr1_en |-> pad_oe[3] == dir_q[3]);

    a_r5_clock_pin: assert property (@(posedge clk) disable iff (rst)
        spi_en |-> (pad_oe[PIN_SCK] == spi_master && pad_out[PIN_SCK] == spi_sck_o));

    a_r6_miso_pin: assert property (@(posedge clk) disable iff (rst)
        spi_en |-> (pad_oe[PIN_MISO] == !spi_master && pad_out[PIN_MISO] == spi_miso_o));

    a_r7_ss_input: assert property (@(posedge clk) disable iff (rst)
        (spi_en && !(spi_master && !spi_modf_en)) |-> !pad_oe[PIN_SS]);

    a_r9_tc1_dir: assert property (@(posedge clk) disable iff (rst)
        tmr1_en |-> pad_oe[3] == tmr1_oe);

    a_r10_tx_drive: assert property (@(posedge clk) disable iff (rst)
        uart_tx_en |-> (pad_oe[PIN_TX] && pad_out[PIN_TX] == uart_tx_o));

    a_r10_rx_input: assert property (@(posedge clk) disable iff (rst)
        uart_rx_en |-> !pad_oe[PIN_RX]);

    a_r11_no_write: assert property (@(posedge clk) disable iff (rst)
        !bus_sel |=> ($stable(data_q) && $stable(dir_q)));
endmodule

bind gpio_share_port gpio_share_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .spi_en     (spi_en),
    .spi_master (spi_master),
    .spi_modf_en(spi_modf_en),
    .spi_sck_o  (spi_sck_o),
    .spi_miso_o (spi_miso_o),
    .tmr1_en    (tmr1_en),
    .tmr1_oe    (tmr1_oe),
    .uart_rx_en (uart_rx_en),
    .uart_tx_en (uart_tx_en),
    .uart_tx_o  (uart_tx_o),
    .pad_out    (pad_out),
    .pad_oe     (pad_oe),
    .data_q     (data_q),
    .dir_q      (dir_q)
);

// File: tb/gpio_share_port_test.sv
module gpio_share_port_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_sel = 0, bus_wr = 0, bus_addr = 0;
    logic [7:0] bus_wdata = 0, pad_in = 0;
    logic [7:0] bus_rdata, pad_out, pad_oe;
    logic spi_en = 0, spi_master = 0, spi_modf_en = 0;
    logic spi_sck_o = 0, spi_mosi_o = 0, spi_miso_o = 0;
    logic tmr1_en = 0, tmr1_oe = 0, tmr1_o = 0;
    logic tmr0_en = 0, tmr0_oe = 0, tmr0_o = 0;
    logic uart_rx_en = 0, uart_tx_en = 0, uart_tx_o = 0;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [7:0] m_data = 8'h00;
    logic [7:0] m_dir  = 8'h00;
    bit         m_known = 0;

    always #2.5 clk = ~clk;

    gpio_share_port uut (.*);

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic expect_pin(int i, output logic oe, output logic val,
                              output string tag);
        oe = m_dir[i]; val = m_data[i]; tag = "R3";
        case (i)
            7: if (spi_en) begin oe = spi_master;  val = spi_sck_o;  tag = "R5"; end
            6: if (spi_en) begin oe = spi_master;  val = spi_mosi_o; tag = "R5"; end
            5: if (spi_en) begin oe = !spi_master; val = spi_miso_o; tag = "R6"; end
            4: if (spi_en && !(spi_master && !spi_modf_en)) begin
                   oe = 0; val = 0; tag = "R7";
               end else if (spi_en) tag = "R7";
            3: if (tmr1_en) begin oe = tmr1_oe; val = tmr1_o; tag = "R9"; end
            2: if (tmr0_en) begin oe = tmr0_oe; val = tmr0_o; tag = "R9"; end
            1: if (uart_rx_en) begin oe = 0; val = 0; tag = "R10"; end
            0: if (uart_tx_en) begin oe = 1; val = uart_tx_o; tag = "R10"; end
            default: ;
        endcase
    endtask

    task automatic compare_all();
        logic [7:0] eoe, eout;
        bit gpio_data;
        bit read_ok = 1;
        for (int i = 0; i < 8; i++) begin
            logic o, v;
            string t;
            expect_pin(i, o, v, t);
            eoe[i] = o; eout[i] = v;
            chk($sformatf("%s pin%0d oe", t, i), {7'd0, pad_oe[i]}, {7'd0, o});
            gpio_data = (t == "R3") || (t == "R7" && !(spi_en && !(spi_master && !spi_modf_en)));
            if (gpio_data && !m_known) read_ok = 0;
            else chk($sformatf("%s pin%0d out", (t == "R3") ? "R2" : t, i),
                     {7'd0, pad_out[i]}, {7'd0, v});
        end
        if (!bus_sel) chk("R4 idle read", bus_rdata, 8'h00);
        else if (bus_addr) chk("R3 dir read", bus_rdata, m_dir);
        else if (read_ok) chk("R4 data read", bus_rdata, (eoe & eout) | (~eoe & pad_in));
    endtask

    task automatic cycle();
        logic [7:0] nd = m_data, nr = m_dir;
        bit nk = m_known;
        if (rst) nr = 8'h00;
        else if (bus_sel && bus_wr) begin
            if (bus_addr) nr = bus_wdata;
            else begin nd = bus_wdata; nk = 1; end
        end
        @(posedge clk);
        m_data = nd; m_dir = nr; m_known = nk;
        #1;
        compare_all();
    endtask

    task automatic wr(logic a, logic [7:0] d);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        cycle();
        bus_wr = 0;
    endtask

    task automatic spi_mode(logic en, logic m, logic f);
        spi_en = en; spi_master = m; spi_modf_en = f;
        for (int k = 0; k < 3; k++) begin
            spi_sck_o = k[0]; spi_mosi_o = ~k[0]; spi_miso_o = k[1];
            pad_in = 8'h5C ^ {k[1:0], 6'd0};
            bus_addr = k[0];
            cycle();
        end
    endtask

    initial begin
        #1000000;
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        rst = 1; bus_sel = 1; bus_addr = 1;
        cycle(); cycle();
        chk("R1 oe after reset", pad_oe, 8'h00);
        chk("R1 dir read after reset", bus_rdata, 8'h00);
        #1; rst = 0;

        // R2, R3, R4: port mode
        wr(0, 8'hA5);
        wr(1, 8'h0F);
        chk("R3 oe follows dir", pad_oe, 8'h0F);
        chk("R2 pad_out latch", pad_out, 8'hA5);
        bus_addr = 0; pad_in = 8'h3C; cycle();
        chk("R4 mixed read", bus_rdata, 8'h35);

        // R11: write with select low
        bus_sel = 0; bus_wr = 1; bus_addr = 0; bus_wdata = 8'h00; cycle();
        bus_addr = 1; cycle();
        bus_wr = 0; bus_sel = 1; bus_addr = 1; cycle();
        chk("R11 dir unchanged", bus_rdata, 8'h0F);
        chk("R11 latch unchanged", pad_out, 8'hA5);

        // SPI modes, with direction all ones, then all zeros
        for (int d = 0; d < 2; d++) begin
            wr(1, d == 0 ? 8'hFF : 8'h00);
            spi_mode(1, 1, 0);
            if (d == 0) chk("R7 ss port mode in master", {7'd0, pad_oe[4]}, 8'h01);
            spi_mode(1, 1, 1);
            chk("R7 ss input with fault detect", {7'd0, pad_oe[4]}, 8'h00);
            spi_mode(1, 0, 0);
            chk("R5 slave clock input", {6'd0, pad_oe[7:6]}, 8'h00);
            chk("R6 slave miso drives", {7'd0, pad_oe[5]}, 8'h01);
            spi_mode(1, 0, 1);
            spi_mode(0, 1, 1);
        end

        // R9: timer channels against opposite direction
        wr(1, 8'h00);
        tmr1_en = 1; tmr1_oe = 1; tmr1_o = 1; tmr0_en = 1; tmr0_oe = 0; tmr0_o = 1;
        cycle();
        chk("R9 timer pins oe", {6'd0, pad_oe[3:2]}, 8'h02);
        wr(1, 8'hFF);
        tmr1_oe = 0; tmr0_oe = 1; tmr0_o = 0; cycle();
        chk("R9 timer pins swapped", {6'd0, pad_oe[3:2]}, 8'h01);
        tmr1_en = 0; tmr0_en = 0; cycle();

        // R10: UART pins
        wr(1, 8'h02);
        uart_rx_en = 1; uart_tx_en = 1; uart_tx_o = 0; cycle();
        chk("R10 uart oe", {6'd0, pad_oe[1:0]}, 8'h01);
        uart_tx_o = 1; cycle();
        uart_rx_en = 0; uart_tx_en = 0; cycle();

        // R8: latch survives reset
        wr(0, 8'h5A);
        rst = 1; cycle(); cycle();
        rst = 0;
        wr(1, 8'hFF);
        chk("R8 latch kept over reset", pad_out, 8'h5A);

        // random traffic
        for (int n = 0; n < 400; n++) begin
            logic [31:0] r = $urandom;
            bus_sel = r[0]; bus_wr = r[1]; bus_addr = r[2]; bus_wdata = r[15:8];
            pad_in = r[23:16];
            spi_en = r[3]; spi_master = r[4]; spi_modf_en = r[5];
            spi_sck_o = r[6]; spi_mosi_o = r[7]; spi_miso_o = r[24];
            tmr1_en = r[25]; tmr1_oe = r[26]; tmr1_o = r[27];
            tmr0_en = r[28]; tmr0_oe = r[29]; tmr0_o = r[30];
            uart_rx_en = r[31]; uart_tx_en = r[9]; uart_tx_o = r[17];
            cycle();
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule